// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block walks a register-select mask and turns one multi-register load or store request into a run of single-word transfers. The request carries a base address, a 16-bit mask, a direction, an addressing mode and a writeback flag. The block issues one transfer per accepted memory handshake. Each transfer carries a word address and the index of the register it serves. After the last transfer it raises a one-cycle completion pulse and presents the base value that the register file should keep.

The transfer count N is the number of set bits in the mask. The mode sets where the run starts. Whatever the mode, the transfers go upward in address: the lowest-numbered selected register goes to the lowest address and each later transfer sits one word (4 bytes) higher. An optional stack-style selector overrides the mode. It picks the real mode from the stack discipline and the direction, so that a push and the matching pop use opposite modes.

Top module: `lsm_seq`

## Requirements
- R1: Mode code 0 (increment-after) places the first transfer at the base and the last at base + 4*N - 4.
- R2: Mode code 1 (increment-before) places the first transfer at base + 4 and the last at base + 4*N.
- R3: Mode code 2 (decrement-after) places the first transfer at base - 4*N + 4 and the last at the base.
- R4: Mode code 3 (decrement-before) places the first transfer at base - 4*N and the last at base - 4.
- R5: With writeback set, the reported base is base + 4*N for mode codes 0 and 1 and base - 4*N for codes 2 and 3. With writeback clear, the reported base equals the request base.
- R6: When the stack selector is set on a load (`req_load`=1), stack code 0 (full-descending) acts as mode 0, code 1 (full-ascending) as mode 2, code 2 (empty-ascending) as mode 3, and code 3 (empty-descending) as mode 1. `req_mode` is then ignored.
- R7: When the stack selector is set on a store (`req_load`=0), stack code 0 acts as mode 3, code 1 as mode 1, code 2 as mode 0, and code 3 as mode 2.
- R8: Exactly N transfers are issued, in ascending register index. Each address is 4 above the previous one, so the lowest selected index gets the lowest address.
- R9: An all-zero mask issues no transfer. `done` rises in the cycle after acceptance, and the reported base equals the request base.
- R10: A transfer stays presented, with its address and register index unchanged, until `mem_ack` is seen high at a clock edge.
- R11: `req_ready` is high only while idle. A request offered while busy is ignored and leaves the transfer run unchanged.
- R12: `done` is high for exactly one cycle, in the cycle after the last acknowledged transfer. `mem_write` is high for stores and low for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | High while idle, so a request can be taken |
| req_base | input | 32 | Base address |
| req_mask | input | 16 | Register-select mask, bit i selects register i |
| req_load | input | 1 | 1 = load, 0 = store |
| req_mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| req_wb | input | 1 | Writeback of the updated base |
| req_stk | input | 1 | Use the stack code instead of `req_mode` |
| req_stk_kind | input | 2 | 0 full-desc, 1 full-asc, 2 empty-asc, 3 empty-desc |
| mem_valid | output | 1 | Transfer presented |
| mem_addr | output | 32 | Word address of the transfer |
| mem_reg | output | 4 | Register index of the transfer |
| mem_write | output | 1 | 1 for a store transfer |
| mem_ack | input | 1 | Memory accepts the presented transfer |
| done | output | 1 | One-cycle completion pulse |
| base_out | output | 32 | Updated base, valid with `done` |

## Verification
The assertions assume that request fields are sampled only in the accept cycle, and that `mem_ack` is meaningful only while `mem_valid` is high. Under those assumptions, the checks on address stepping, register ordering and handshake holding rely on each run starting from a fresh accept. The bench drives every request for a single cycle while `req_ready` is high. It raises `mem_ack` only while a transfer is shown, with set wait counts. A junk request held during a busy run is dropped before the block returns to idle.

// File: rtl/lsm_pkg.sv
// Shared encodings for the block transfer sequencer.
package lsm_pkg;
    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } addr_mode_t;

    typedef enum logic [1:0] {
        SK_FULL_DESC  = 2'd0,
        SK_FULL_ASC   = 2'd1,
        SK_EMPTY_ASC  = 2'd2,
        SK_EMPTY_DESC = 2'd3
    } stack_kind_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_MOVE = 2'd1,
        SQ_FIN  = 2'd2
    } seq_state_t;

    // Returns 1 when the mode counts downward from the base.
    function automatic logic mode_is_down(input addr_mode_t m);
        return (m == AM_DEC_AFTER) || (m == AM_DEC_BEFORE);
    endfunction
endpackage

// File: rtl/lsm_mode_xlate.sv
// lsm_mode_xlate: picks the effective addressing mode.
// Assumes: stack codes follow lsm_pkg::stack_kind_t; purely combinational.
module lsm_mode_xlate
    import lsm_pkg::*;
(
    input  logic       use_stack,
    input  logic [1:0] stack_kind,
    input  logic       is_load,
    input  logic [1:0] mode_in,
    output logic [1:0] mode_out
);
    stack_kind_t sk;
    addr_mode_t  stk_mode;

    assign sk = stack_kind_t'(stack_kind);

    // Stack discipline to mode; loads and stores pick opposite modes.
    always_comb begin
        stk_mode = AM_INC_AFTER;
        unique case (sk)
            SK_FULL_DESC:  stk_mode = is_load ? AM_INC_AFTER  : AM_DEC_BEFORE;
            SK_FULL_ASC:   stk_mode = is_load ? AM_DEC_AFTER  : AM_INC_BEFORE;
            SK_EMPTY_ASC:  stk_mode = is_load ? AM_DEC_BEFORE : AM_INC_AFTER;
            SK_EMPTY_DESC: stk_mode = is_load ? AM_INC_BEFORE : AM_DEC_AFTER;
            default:       stk_mode = AM_INC_AFTER;
        endcase
    end

    // Stack code overrides the plain mode when selected.
    always_comb begin
        mode_out = use_stack ? stk_mode : mode_in;
    end
endmodule

// File: rtl/lsm_addr_plan.sv
// lsm_addr_plan: counts the selected registers and derives the first
// transfer address and the final base from mode, base and count.
// Assumes: addresses wrap modulo 2**ADDR_W; purely combinational.
module lsm_addr_plan
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [NREG-1:0]   mask,
    input  logic [1:0]        mode,
    input  logic              wb,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] final_base
);
    localparam int CNT_W = $clog2(NREG + 1);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] span;
    addr_mode_t        am;

    assign am = addr_mode_t'(mode);

    // Population count of the mask.
    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) begin
            count = count + CNT_W'(mask[i]);
        end
    end

    // Byte span covered by the whole run.
    always_comb begin
        span = ADDR_W'(count) * STEP_V;
    end

    // First address of the ascending run for each mode.
    always_comb begin
        start_addr = base;
        unique case (am)
            AM_INC_AFTER:  start_addr = base;
            AM_INC_BEFORE: start_addr = base + STEP_V;
            AM_DEC_AFTER:  start_addr = base - span + STEP_V;
            AM_DEC_BEFORE: start_addr = base - span;
            default:       start_addr = base;
        endcase
    end

    // Base value handed back after the run.
    always_comb begin
        if (!wb) begin
            final_base = base;
        end else if (mode_is_down(am)) begin
            final_base = base - span;
        end else begin
            final_base = base + span;
        end
    end
endmodule

// File: rtl/lsm_mask_walker.sv
// lsm_mask_walker: holds the registers still to move and names the
// lowest one; clears it on each step.
// Assumes: load and step are never high together.
module lsm_mask_walker #(
    parameter int NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [NREG-1:0]         mask_in,
    input  logic                    step,
    output logic [$clog2(NREG)-1:0] cur_idx,
    output logic                    last
);
    localparam int IDX_W = $clog2(NREG);

    logic [NREG-1:0] rem_q;
    logic [NREG-1:0] low_bit;

    // Isolate the lowest pending bit.
    always_comb begin
        low_bit = rem_q & (~rem_q + NREG'(1));
    end

    // Encode the isolated bit as an index.
    always_comb begin
        cur_idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (low_bit[i]) begin
                cur_idx = IDX_W'(i);
            end
        end
    end

    // Exactly one register remains.
    always_comb begin
        last = (rem_q != '0) && ((rem_q & (rem_q - NREG'(1))) == '0);
    end

    // Pending-register store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= mask_in;
        end else if (step) begin
            rem_q <= rem_q & ~low_bit;
        end
    end
endmodule

// File: rtl/lsm_seq.sv
// lsm_seq: multi-register transfer sequencer top. Takes a request when
// idle, issues one word transfer per acknowledged handshake in ascending
// address order, then pulses done with the updated base.
// Assumes: request fields are valid in the accept cycle only.
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    parameter int STEP   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_base,
    input  logic [NREG-1:0]         req_mask,
    input  logic                    req_load,
    input  logic [1:0]              req_mode,
    input  logic                    req_wb,
    input  logic                    req_stk,
    input  logic [1:0]              req_stk_kind,
    output logic                    mem_valid,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [$clog2(NREG)-1:0] mem_reg,
    output logic                    mem_write,
    input  logic                    mem_ack,
    output logic                    done,
    output logic [ADDR_W-1:0]       base_out
);
    localparam int IDX_W = $clog2(NREG);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] base_q;
    logic              write_q;
    logic [1:0]        eff_mode;
    logic [ADDR_W-1:0] plan_start;
    logic [ADDR_W-1:0] plan_final;
    logic [IDX_W-1:0]  walk_idx;
    logic              walk_last;
    logic              accept;
    logic              step;

    // Handshake strobes.
    assign accept = req_valid && (state_q == SQ_IDLE);
    assign step   = (state_q == SQ_MOVE) && mem_ack;

    lsm_mode_xlate u_xlate (
        .use_stack  (req_stk),
        .stack_kind (req_stk_kind),
        .is_load    (req_load),
        .mode_in    (req_mode),
        .mode_out   (eff_mode)
    );

    lsm_addr_plan #(
        .ADDR_W (ADDR_W),
        .NREG   (NREG),
        .STEP   (STEP)
    ) u_plan (
        .base       (req_base),
        .mask       (req_mask),
        .mode       (eff_mode),
        .wb         (req_wb),
        .start_addr (plan_start),
        .final_base (plan_final)
    );

    lsm_mask_walker #(
        .NREG (NREG)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .mask_in (req_mask),
        .step    (step),
        .cur_idx (walk_idx),
        .last    (walk_last)
    );

    // Sequencer state, running address and captured request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            base_q  <= '0;
            write_q <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        addr_q  <= plan_start;
                        base_q  <= plan_final;
                        write_q <= !req_load;
                        state_q <= (req_mask == '0) ? SQ_FIN : SQ_MOVE;
                    end
                end
                SQ_MOVE: begin
                    if (step) begin
                        addr_q <= addr_q + STEP_V;
                        if (walk_last) begin
                            state_q <= SQ_FIN;
                        end
                    end
                end
                SQ_FIN: begin
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Output decode from registered state.
    always_comb begin
        req_ready = (state_q == SQ_IDLE);
        mem_valid = (state_q == SQ_MOVE);
        mem_addr  = addr_q;
        mem_reg   = walk_idx;
        mem_write = write_q;
        done      = (state_q == SQ_FIN);
        base_out  = base_q;
    end
endmodule

// File: rtl/lsm_seq_chk.sv
// lsm_seq_chk: protocol properties for lsm_seq, bound to the top.
// Assumes: mem_ack is only meaningful while mem_valid is high.
module lsm_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [NREG-1:0]         req_mask,
    input logic                    mem_valid,
    input logic                    mem_ack,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [$clog2(NREG)-1:0] mem_reg,
    input logic                    done
);
    // R10: an unacknowledged transfer stays put.
    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_reg)));

    // R8: consecutive transfers step up one word.
    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ack) |=> (!mem_valid || (mem_addr == $past(mem_addr) + ADDR_W'(4))));

    // R8: register indices climb.
    a_r8_reg_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ack) |=> (!mem_valid || (mem_reg > $past(mem_reg))));

    // R11: never ready while a transfer is shown.
    a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && mem_valid));

    // R12: done is a single-cycle pulse.
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: empty mask completes at once with no transfer.
    a_r9_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_mask == '0)) |=> (done && !mem_valid));
endmodule

bind lsm_seq lsm_seq_chk #(
    .ADDR_W (ADDR_W),
    .NREG   (NREG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .mem_valid (mem_valid),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_reg   (mem_reg),
    .done      (done)
);

// File: tb/lsm_seq_bench.sv
// Directed bench for lsm_seq: one task per scenario, memory side modelled
// by acknowledging each transfer after a set wait.
module lsm_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_base = '0;
    logic [15:0] req_mask = '0;
    logic        req_load = 1'b0;
    logic [1:0]  req_mode = '0;
    logic        req_wb = 1'b0;
    logic        req_stk = 1'b0;
    logic [1:0]  req_stk_kind = '0;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [3:0]  mem_reg;
    logic        mem_write;
    logic        mem_ack = 1'b0;
    logic        done;
    logic [31:0] base_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    lsm_seq u_lsm_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_base     (req_base),
        .req_mask     (req_mask),
        .req_load     (req_load),
        .req_mode     (req_mode),
        .req_wb       (req_wb),
        .req_stk      (req_stk),
        .req_stk_kind (req_stk_kind),
        .mem_valid    (mem_valid),
        .mem_addr     (mem_addr),
        .mem_reg      (mem_reg),
        .mem_write    (mem_write),
        .mem_ack      (mem_ack),
        .done         (done),
        .base_out     (base_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Expected mode for a stack code, from R6 and R7.
    function automatic logic [1:0] stack_mode(input logic [1:0] kind, input logic ld);
        case (kind)
            2'd0:    return ld ? 2'd0 : 2'd3;
            2'd1:    return ld ? 2'd2 : 2'd1;
            2'd2:    return ld ? 2'd3 : 2'd0;
            default: return ld ? 2'd1 : 2'd2;
        endcase
    endfunction

    // Runs one request; tag names the requirement the addresses test.
    task automatic run_case(input string tag, input logic [31:0] base, input logic [15:0] mask,
                            input logic ld, input logic [1:0] mode, input logic wb,
                            input logic stk, input logic [1:0] kind, input int dly,
                            input logic junk);
        logic [1:0]  em;
        int          n;
        int          k;
        logic [31:0] span;
        logic [31:0] start;
        logic [31:0] fin;
        em = stk ? stack_mode(kind, ld) : mode;
        n = $countones(mask);
        span = 32'(n) * 32'd4;
        case (em)
            2'd0:    start = base;
            2'd1:    start = base + 32'd4;
            2'd2:    start = base - span + 32'd4;
            default: start = base - span;
        endcase
        fin = !wb ? base : (em[1] ? base - span : base + span);

        @(negedge clk);
        chk({tag, " R11 ready when idle"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_base = base; req_mask = mask; req_load = ld;
        req_mode = stk ? ~em : mode; req_wb = wb; req_stk = stk; req_stk_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (mask[i]) begin
                for (int w = 0; w < dly; w++) begin
                    chk({tag, " R10 held valid"}, 32'(mem_valid), 32'd1);
                    chk({tag, " R10 held addr"}, mem_addr, start + 32'(k) * 32'd4);
                    @(negedge clk);
                end
                chk({tag, " R8 valid"}, 32'(mem_valid), 32'd1);
                chk({tag, " addr"}, mem_addr, start + 32'(k) * 32'd4);
                chk({tag, " R8 reg index"}, 32'(mem_reg), 32'(i));
                chk({tag, " R12 write flag"}, 32'(mem_write), 32'(!ld));
                chk({tag, " R11 not ready while busy"}, 32'(req_ready), 32'd0);
                if (junk && k == 0) begin
                    req_valid = 1'b1; req_base = 32'hDEAD_0000; req_mask = 16'hFFFF;
                    req_mode = 2'd3; req_load = !ld;
                end
                if (junk && k == n - 1) req_valid = 1'b0;
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
                k++;
            end
        end
        if (n == 0) chk({tag, " R9 no transfer"}, 32'(mem_valid), 32'd0);
        chk({tag, " R12 done after last"}, 32'(done), 32'd1);
        chk({tag, " R8 no extra transfer"}, 32'(mem_valid), 32'd0);
        chk({tag, " R5 base"}, base_out, fin);
        @(negedge clk);
        chk({tag, " R12 done one cycle"}, 32'(done), 32'd0);
        chk({tag, " R11 idle again"}, 32'(req_ready), 32'd1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R11 reset ready", 32'(req_ready), 32'd1);
        chk("R12 reset done", 32'(done), 32'd0);
        chk("R10 reset valid", 32'(mem_valid), 32'd0);
    endtask

    task automatic test_plain_modes();
        run_case("R1", 32'h0000_1000, 16'h000F, 1'b1, 2'd0, 1'b1, 1'b0, 2'd0, 0, 1'b0);
        run_case("R2", 32'h0000_1000, 16'h8001, 1'b0, 2'd1, 1'b1, 1'b0, 2'd0, 1, 1'b0);
        run_case("R3", 32'h0000_1100, 16'h0124, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 2, 1'b0);
        run_case("R4", 32'h0000_1100, 16'h00F0, 1'b0, 2'd3, 1'b1, 1'b0, 2'd0, 0, 1'b0);
        run_case("R5", 32'h0000_2000, 16'h0C30, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 0, 1'b0);
    endtask

    task automatic test_stack_aliases();
        for (int kd = 0; kd < 4; kd++) begin
            run_case("R6", 32'h0000_3000, 16'h1241, 1'b1, 2'd0, 1'b1, 1'b1, 2'(kd), kd & 1, 1'b0);
            run_case("R7", 32'h0000_3000, 16'h0816, 1'b0, 2'd0, 1'b1, 1'b1, 2'(kd), 0, 1'b0);
        end
    endtask

    task automatic test_empty_mask();
        run_case("R9", 32'h0000_4444, 16'h0000, 1'b1, 2'd3, 1'b1, 1'b0, 2'd0, 0, 1'b0);
    endtask

    task automatic test_busy_ignore();
        run_case("R11", 32'h0000_5000, 16'h00A5, 1'b0, 2'd2, 1'b1, 1'b0, 2'd0, 1, 1'b1);
    endtask

    task automatic test_full_mask();
        run_case("R4", 32'h0001_0000, 16'hFFFF, 1'b1, 2'd3, 1'b1, 1'b0, 2'd0, 1, 1'b0);
        run_case("R10", 32'h0000_0000, 16'h4000, 1'b0, 2'd2, 1'b1, 1'b0, 2'd0, 3, 1'b0);
    endtask

    // Watchdog: counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_plain_modes();
        test_stack_aliases();
        test_empty_mask();
        test_busy_ignore();
        test_full_mask();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule